// File: doc/BRIEF.md
# UART Channel Disable Controller

This block sits between a UART's serial front end and its FIFOs and gates both directions under register control. On the receive side it decides whether the shift register may start a new character. It also decides whether a finished character is written into the RX FIFO, and whether a finished character is compared against the programmable flow-control codes. A receiver disable never cuts a character in half. A character already in flight is completed and stored, and only then does the receiver stop.

Separate mode bits decide what still happens while a direction is disabled. On the receive side, the mode chooses between ignoring everything and snooping for XON/XOFF codes while data is discarded. On the transmit side, the mode chooses between letting out only the flow-control character that was already pending and continuing to send flow-control characters. Turning the receiver back on waits until the serial line has stayed high for a full character time. This keeps a half-seen frame from reaching the FIFO.

Top module: `uart_chan_gate`

## Requirements
- R1: After reset the receiver is enabled, all receive outputs are low, and a transmit data request with `tx_ready` high is granted at once.
- R2: With the receiver enabled, a character accepted on `rx_start` produces exactly one `fifo_wr` pulse, in the same cycle as its `rx_done`, and `fifo_wr` is low in the following cycle.
- R3: Setting `rx_dis` while a character is in progress still writes that character; the next character is not written.
- R4: Setting `rx_dis` while the receiver is idle stops acceptance; with `rx_mode` = 0 `rx_shift_en` drops low and later characters are not written.
- R5: While disabled with `rx_mode` = 0, received characters give neither a FIFO write nor any detect pulse, including XON/XOFF values.
- R6: While disabled with `rx_mode` = 1, characters never reach the FIFO, but XON/XOFF values still give their detect pulses.
- R7: `xon_det` / `xoff_det` pulse for one cycle, with `rx_done`, exactly when the finished character equals the programmable `xon_char` / `xoff_char`.
- R8: After `rx_dis` is cleared, the receiver only resumes once `rx_line` has been high for `CHAR_CYCLES` consecutive cycles. Characters that start earlier are not written; after that time the next character is written normally.
- R9: With the transmitter enabled, a grant needs `tx_ready`, and a flow-control request wins over a data request. At most one grant is high in any cycle.
- R10: With `tx_dis` = 1 and `tx_mode` = 0, data is never granted. A flow-control request that was pending when the disable was sampled is granted once. Flow-control requests after that are refused.
- R11: With `tx_dis` = 1 and `tx_mode` = 1, flow-control requests keep being granted, and data stays blocked.
- R12: An `rx_done` with no accepted character in flight is ignored, and an `rx_start` during a character in flight does not start a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dis | input | 1 | Receiver disable request |
| rx_mode | input | 1 | 1: keep XON/XOFF snooping while receiver disabled |
| tx_dis | input | 1 | Transmitter disable request |
| tx_mode | input | 1 | 1: keep sending flow-control characters while transmitter disabled |
| xon_char | input | DW | Programmable XON code |
| xoff_char | input | DW | Programmable XOFF code |
| rx_line | input | 1 | Serial receive line level (high = idle) |
| rx_start | input | 1 | Start-bit detected strobe from the shift register |
| rx_done | input | 1 | Stop-bit completed strobe from the shift register |
| rx_data | input | DW | Character assembled by the shift register |
| rx_shift_en | output | 1 | Shift register may run / start a new character |
| fifo_wr | output | 1 | RX FIFO write enable |
| xon_det | output | 1 | XON received pulse |
| xoff_det | output | 1 | XOFF received pulse |
| tx_ready | input | 1 | Transmit shift register can take a character |
| tx_fc_req | input | 1 | Flow-control character waiting to be sent |
| tx_data_req | input | 1 | Data character waiting to be sent |
| tx_fc_go | output | 1 | Grant to send the flow-control character |
| tx_data_go | output | 1 | Grant to send a data character |

## Verification
The hardest state to reach is a re-enable while the line is still busy. The bench starts a character with the receiver disabled and clears `rx_dis` in the middle of it. It then sends a second character within a few cycles of the first stop bit, so the idle window has not yet filled. Neither character may be written, while a third one sent after a full quiet character time must be written. A second hard state is the flow-control carry on the transmit side. The bench holds a flow-control request against a busy transmitter across the disable edge, so that the request is pending but not yet granted. It then checks that exactly one grant follows and that a repeated request is refused.

// File: rtl/uart_chan_gate.sv
module uart_chan_gate #(
  parameter int CHAR_CYCLES = 160,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_dis,
  input  logic          rx_mode,
  input  logic          tx_dis,
  input  logic          tx_mode,
  input  logic [DW-1:0] xon_char,
  input  logic [DW-1:0] xoff_char,
  input  logic          rx_line,
  input  logic          rx_start,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_data,
  output logic          rx_shift_en,
  output logic          fifo_wr,
  output logic          xon_det,
  output logic          xoff_det,
  input  logic          tx_ready,
  input  logic          tx_fc_req,
  input  logic          tx_data_req,
  output logic          tx_fc_go,
  output logic          tx_data_go
);
  localparam int CW = $clog2(CHAR_CYCLES + 1);

  logic          rx_on;
  logic          rx_busy;
  logic          rx_keep;
  logic          tx_off;
  logic          fc_carry;
  logic [CW-1:0] idle_cnt;

  logic data_ok, start_ok, idle_full, fin, watch;

  assign data_ok   = rx_on & ~rx_dis;
  assign start_ok  = rx_start & ~rx_busy & (data_ok | rx_mode);
  assign idle_full = (idle_cnt == CW'(CHAR_CYCLES));
  assign fin       = rx_done & rx_busy;
  assign watch     = rx_keep | rx_mode;

  assign rx_shift_en = rx_busy | data_ok | rx_mode;
  assign fifo_wr     = fin & rx_keep;
  assign xon_det     = fin & watch & (rx_data == xon_char);
  assign xoff_det    = fin & watch & (rx_data == xoff_char);

  assign tx_fc_go   = tx_fc_req & tx_ready & (~tx_off | tx_mode | fc_carry);
  assign tx_data_go = tx_data_req & tx_ready & ~tx_off & ~tx_fc_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_on    <= 1'b1;
      rx_busy  <= 1'b0;
      rx_keep  <= 1'b0;
      idle_cnt <= '0;
      tx_off   <= 1'b0;
      fc_carry <= 1'b0;
    end else begin
      if (!rx_line)       idle_cnt <= '0;
      else if (!idle_full) idle_cnt <= idle_cnt + CW'(1);

      if (start_ok) begin
        rx_busy <= 1'b1;
        rx_keep <= data_ok;
      end else if (rx_done) begin
        rx_busy <= 1'b0;
        rx_keep <= 1'b0;
      end

      if (rx_on) rx_on <= ~(rx_dis & (~rx_busy | rx_done));
      else       rx_on <= ~rx_dis & idle_full & rx_line;

      tx_off   <= tx_dis;
      fc_carry <= tx_dis & (fc_carry ? ~tx_fc_go
                                     : (~tx_off & tx_fc_req & ~tx_fc_go));
    end
  end
endmodule

module uart_chan_gate_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_dis,
  input logic          rx_line,
  input logic          rx_done,
  input logic [DW-1:0] rx_data,
  input logic [DW-1:0] xon_char,
  input logic [DW-1:0] xoff_char,
  input logic          fifo_wr,
  input logic          xon_det,
  input logic          xoff_det,
  input logic          rx_on,
  input logic          tx_dis,
  input logic          tx_ready,
  input logic          tx_fc_go,
  input logic          tx_data_go
);
  assert_wr_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> rx_done);
  assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |=> !fifo_wr);
  assert_xon_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xon_det |-> (rx_done && rx_data == xon_char));
  assert_xoff_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_det |-> (rx_done && rx_data == xoff_char));
  assert_resume_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_on) |-> ($past(rx_line) && !$past(rx_dis)));
  assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_fc_go && tx_data_go));
  assert_grant_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fc_go || tx_data_go) |-> tx_ready);
  assert_no_data_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_data_go |-> !$past(tx_dis));
endmodule

bind uart_chan_gate uart_chan_gate_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_uart_chan_gate.sv
module sim_uart_chan_gate;
  localparam int CC = 12;
  logic clk = 0, rst_n = 0;
  logic rx_dis = 0, rx_mode = 0, tx_dis = 0, tx_mode = 0;
  logic [7:0] xon_char = 8'h11, xoff_char = 8'h13, rx_data = 0;
  logic rx_line = 1, rx_start = 0, rx_done = 0;
  logic tx_ready = 0, tx_fc_req = 0, tx_data_req = 0;
  logic rx_shift_en, fifo_wr, xon_det, xoff_det, tx_fc_go, tx_data_go;
  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  uart_chan_gate #(.CHAR_CYCLES(CC), .DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_dis(rx_dis), .rx_mode(rx_mode),
    .tx_dis(tx_dis), .tx_mode(tx_mode), .xon_char(xon_char), .xoff_char(xoff_char),
    .rx_line(rx_line), .rx_start(rx_start), .rx_done(rx_done), .rx_data(rx_data),
    .rx_shift_en(rx_shift_en), .fifo_wr(fifo_wr), .xon_det(xon_det), .xoff_det(xoff_det),
    .tx_ready(tx_ready), .tx_fc_req(tx_fc_req), .tx_data_req(tx_data_req),
    .tx_fc_go(tx_fc_go), .tx_data_go(tx_data_go));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send_char(input logic [7:0] d, input logic chg, input logic chg_val,
                           input logic ew, input logic eon, input logic eoff,
                           input string tag);
    @(negedge clk) rx_line = 0; rx_start = 1;
    @(negedge clk) rx_start = 0; if (chg) rx_dis = chg_val;
    repeat (2) @(negedge clk);
    rx_data = d; rx_done = 1;
    #1;
    chk({tag, " fifo_wr"}, fifo_wr, ew);
    chk({tag, " xon_det"}, xon_det, eon);
    chk({tag, " xoff_det"}, xoff_det, eoff);
    @(negedge clk) rx_done = 0; rx_line = 1;
    #1;
    chk({tag, " write gone"}, fifo_wr | xon_det | xoff_det, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tx_ready = 1; tx_data_req = 1;
    #1;
    // R1 reset state
    chk("R1 shift_en", rx_shift_en, 1);
    chk("R1 outputs", {fifo_wr, xon_det, xoff_det, tx_fc_go}, 0);
    chk("R1 data grant", tx_data_go, 1);
    @(negedge clk) tx_ready = 0; tx_data_req = 0;

    // R2 / R7 sweep over every character value with the receiver on
    for (int v = 0; v < 256; v++)
      send_char(v[7:0], 0, 0, 1, v == 8'h11, v == 8'h13, "R2 R7 sweep");

    // R7 programmable codes
    @(negedge clk) xon_char = 8'hA5; xoff_char = 8'h5A;
    send_char(8'hA5, 0, 0, 1, 1, 0, "R7 new xon");
    send_char(8'h11, 0, 0, 1, 0, 0, "R7 old xon");
    send_char(8'h5A, 0, 0, 1, 0, 1, "R7 new xoff");
    @(negedge clk) xon_char = 8'h11; xoff_char = 8'h13;

    // R3 disable in the middle of a character
    send_char(8'h41, 1, 1, 1, 0, 0, "R3 inflight");
    send_char(8'h42, 0, 0, 0, 0, 0, "R3 after");

    // R5 mode 0: everything ignored
    send_char(8'h11, 0, 0, 0, 0, 0, "R5 xon");
    send_char(8'h13, 0, 0, 0, 0, 0, "R5 xoff");

    // R6 mode 1: snoop only
    @(negedge clk) rx_mode = 1;
    send_char(8'h11, 0, 0, 0, 1, 0, "R6 xon");
    send_char(8'h13, 0, 0, 0, 0, 1, "R6 xoff");
    send_char(8'h55, 0, 0, 0, 0, 0, "R6 data");
    @(negedge clk) rx_mode = 0;

    // R8 re-enable on a quiet line
    repeat (CC + 2) @(negedge clk);
    rx_dis = 0;
    send_char(8'h5A, 0, 0, 1, 0, 0, "R8 quiet resume");

    // R4 disable while idle
    repeat (3) @(negedge clk);
    rx_dis = 1;
    @(negedge clk) #1;
    chk("R4 shift_en", rx_shift_en, 0);
    send_char(8'h33, 0, 0, 0, 0, 0, "R4 idle disable");

    // R8 re-enable during activity
    repeat (CC + 2) @(negedge clk);
    send_char(8'h61, 1, 0, 0, 0, 0, "R8 busy resume");
    repeat (2) @(negedge clk);
    send_char(8'h62, 0, 0, 0, 0, 0, "R8 too early");
    repeat (CC + 2) @(negedge clk);
    send_char(8'h63, 0, 0, 1, 0, 0, "R8 after window");

    // R12 stray done and repeated start
    @(negedge clk) rx_done = 1; rx_data = 8'h11;
    #1 chk("R12 stray done", {fifo_wr, xon_det}, 0);
    @(negedge clk) rx_done = 0;
    @(negedge clk) rx_line = 0; rx_start = 1;
    @(negedge clk) rx_start = 0;
    @(negedge clk) rx_start = 1;
    @(negedge clk) rx_start = 0;
    @(negedge clk) rx_done = 1; rx_data = 8'h77;
    #1 chk("R12 single write", fifo_wr, 1);
    @(negedge clk) rx_done = 0; rx_line = 1;
    #1 chk("R12 no second write", fifo_wr, 0);

    // R9 / R10 / R11 sweep of settled transmit states
    for (int c = 0; c < 32; c++) begin
      @(negedge clk) tx_fc_req = 0; tx_dis = c[4]; tx_mode = c[3];
      @(negedge clk) tx_fc_req = c[2]; tx_data_req = c[1]; tx_ready = c[0];
      #1;
      chk(c[4] ? (c[3] ? "R11 fc grant" : "R10 fc grant") : "R9 fc grant", tx_fc_go,
          c[2] & c[0] & (~c[4] | c[3]));
      chk(c[4] ? "R10 R11 data blocked" : "R9 data grant", tx_data_go,
          c[1] & c[0] & ~c[4] & ~c[2]);
    end

    // R10 pending flow-control character carried across the disable
    @(negedge clk) tx_dis = 0; tx_mode = 0; tx_fc_req = 0; tx_data_req = 0; tx_ready = 0;
    @(negedge clk) tx_fc_req = 1;
    @(negedge clk) tx_dis = 1;
    @(negedge clk) #1 chk("R10 held while busy", tx_fc_go, 0);
    @(negedge clk) tx_ready = 1;
    #1 chk("R10 pending sent", tx_fc_go, 1);
    @(negedge clk) #1 chk("R10 new refused", tx_fc_go, 0);
    @(negedge clk) tx_fc_req = 0; tx_dis = 0;

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule